// File: doc/BRIEF.md
# Latched Interrupt Status Unit

This block gathers the interrupt events of a network controller into a single 32-bit sticky status word and drives one level-sensitive interrupt line toward the host. Each event source delivers a one-cycle pulse on its own bit of `evt_i`. Receive, transmit, PHY, management and bus-error sources each have a bit. A pulse sets the matching status bit, and the bit stays set until the host reads the status word. The read returns the accumulated value and clears the word in the same access. A summary bit at position 15 shows whether any of the high-order error and reset-complete bits is set.

A per-bit mask register with the same layout as the status word selects which bits may raise the interrupt. A one-bit global enable gates the line as a whole. The host reaches all three registers through a simple single-cycle register port. The byte offsets are 0x00 for status, 0x04 for mask and 0x08 for enable. Read data is combinational while the port is selected, so the host sees the value in the same cycle. The clearing takes effect at the clock edge that ends the read.

Top module: `irq_latch_unit`

## Requirements
- R1: After reset, the status, mask and enable registers all read zero and `irq_o` is low.
- R2: A pulse on an implemented event bit sets that status bit at the next clock edge. The bit stays set across any number of cycles until the status word is read. The implemented event bits are 0 to 14, 16 and 20 to 25, which is the mask 0x03F17FFF.
- R3: A read at offset 0x00 returns the current status and clears every stored bit at the end of that cycle. A second read with no new events between the two returns zero.
- R4: An event that arrives in the same cycle as a clearing read is not included in that read's data. It is set in the status word after the read.
- R5: Status bit 15 reads as the OR of stored bits 16 through 25. It has no storage of its own, so it clears together with those bits.
- R6: Event pulses on bits 15, 17, 18, 19 and 26 to 31 are ignored. Those status positions read zero except for bit 15 as given in R5.
- R7: The mask register at offset 0x04 resets to zero. It reads back the written value on bits 0 to 25 except 17 to 19, which is the mask 0x03F1FFFF. Its other bits read zero.
- R8: The enable register at offset 0x08 keeps only bit 0 of a write and reads back that bit in position 0, with zeros elsewhere.
- R9: `irq_o` equals the enable bit ANDed with the OR of (status view AND mask), where the status view includes the bit-15 summary. It follows register changes in the same cycle they take effect.
- R10: A write at offset 0x00 changes nothing in the status word. Reads at any offset other than 0x00, 0x04 and 0x08 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | One-cycle event pulses, one bit per status position |
| bus_sel_i | input | 1 | Register port access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while a read is selected |
| irq_o | output | 1 | Level interrupt request |

## Verification
A status bit that is stored or cleared wrongly shows up at the read port. A lost bit makes a read return less than the events delivered. A bit that is not cleared returns a nonzero value on the second of two back-to-back reads. Both can be seen within two accesses. Faults in the mask, the enable or the summary bit change `irq_o` in the same cycle the affected register takes its new value, so the bench samples the line right after each edge that delivers an event or a register write. An event lost in the same cycle as a read is visible only on the read after that one, so the bench sets up that case on purpose.

// File: rtl/irq_latch_unit.sv
module irq_latch_unit #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h00,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h04,
  parameter logic [ADDR_W-1:0] EN_OFS   = 8'h08,
  parameter int SUM_BIT = 15,
  parameter int ERR_LO  = 16,
  parameter int ERR_HI  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       evt_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);
  localparam logic [31:0] EVT_BITS  = 32'h03F1_7FFF;
  localparam logic [31:0] VIEW_BITS = EVT_BITS | (32'd1 << SUM_BIT);

  logic [31:0] stat_q, mask_q, stat_view;
  logic        en_q;

  wire rd_stat = bus_sel_i & ~bus_wr_i & (bus_addr_i == STAT_OFS);
  wire wr_mask = bus_sel_i &  bus_wr_i & (bus_addr_i == MASK_OFS);
  wire wr_en   = bus_sel_i &  bus_wr_i & (bus_addr_i == EN_OFS);

  always_comb begin
    stat_view = stat_q;
    stat_view[SUM_BIT] = |stat_q[ERR_HI:ERR_LO];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      stat_q <= (rd_stat ? 32'd0 : stat_q) | (evt_i & EVT_BITS);
      if (wr_mask) mask_q <= bus_wdata_i & VIEW_BITS;
      if (wr_en)   en_q   <= bus_wdata_i[0];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_wr_i) begin
      if (bus_addr_i == STAT_OFS)      bus_rdata_o = stat_view;
      else if (bus_addr_i == MASK_OFS) bus_rdata_o = mask_q;
      else if (bus_addr_i == EN_OFS)   bus_rdata_o = {31'd0, en_q};
    end
  end

  assign irq_o = en_q & |(stat_view & mask_q);
endmodule

// File: rtl/irq_latch_unit_chk.sv
module irq_latch_unit_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h00
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       evt_i,
  input logic              bus_sel_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_rdata_o,
  input logic              irq_o,
  input logic [31:0]       stat_q,
  input logic [31:0]       mask_q,
  input logic              en_q
);
  localparam logic [31:0] EVT_BITS = 32'h03F1_7FFF;
  wire rd_stat = bus_sel_i && !bus_wr_i && (bus_addr_i == STAT_OFS);

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && ((evt_i & EVT_BITS) == 32'd0)) |=> (stat_q == 32'd0));

  p_keep_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> ((stat_q & $past(evt_i & EVT_BITS)) == $past(evt_i & EVT_BITS)));

  p_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |-> (bus_rdata_o[15] == |bus_rdata_o[25:16]));

  p_unimpl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~EVT_BITS) == 32'd0);

  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q || mask_q == 32'd0) |-> !irq_o);
endmodule

bind irq_latch_unit irq_latch_unit_chk #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_sel_i(bus_sel_i),
  .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o),
  .irq_o(irq_o), .stat_q(stat_q), .mask_q(mask_q), .en_q(en_q)
);

// File: tb/irq_latch_unit_tb_top.sv
`timescale 1ns/1ps
module irq_latch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_i = '0;
  logic        bus_sel_i = 1'b0, bus_wr_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_latch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_sel_i(bus_sel_i),
    .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  // {event pulse, expected status read}
  localparam int NV = 9;
  localparam logic [63:0] VEC [NV] = '{
    {32'h0000_0001, 32'h0000_0001},
    {32'h0000_7FFF, 32'h0000_7FFF},
    {32'h0001_0000, 32'h0001_8000},
    {32'h0010_0000, 32'h0010_8000},
    {32'h03F1_0000, 32'h03F1_8000},
    {32'hFC0E_8000, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'h03F1_FFFF},
    {32'h0200_0400, 32'h0200_8400},
    {32'h0000_0000, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [31:0] e);
    @(negedge clk); evt_i = e;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, output logic [31:0] d);
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = a; evt_i = e;
    #2 d = bus_rdata_o;
    @(negedge clk);
    bus_sel_i = 1'b0; evt_i = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = v;
    @(negedge clk);
    bus_sel_i = 1'b0; bus_wr_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, '0, d); chk("R1 status", d, 32'h0);
    rd(8'h04, '0, d); chk("R1 mask", d, 32'h0);
    rd(8'h08, '0, d); chk("R1 enable", d, 32'h0);
    chk("R1 irq", {31'd0, irq_o}, 32'h0);

    // R2 R3 R5 R6 vector walk
    for (int i = 0; i < NV; i++) begin
      pulse(VEC[i][63:32]);
      repeat (3) @(negedge clk);
      rd(8'h00, '0, d); chk("R2/R5/R6 status read", d, VEC[i][31:0]);
      rd(8'h00, '0, d); chk("R3 second read zero", d, 32'h0);
    end

    // R7 mask readback
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, '0, d); chk("R7 mask all", d, 32'h03F1_FFFF);
    wr(8'h04, 32'h5A5A_5A5A); rd(8'h04, '0, d); chk("R7 mask pattern", d, 32'h0250_5A5A);

    // R8 enable readback
    wr(8'h08, 32'hFFFF_FFFE); rd(8'h08, '0, d); chk("R8 enable bit0 clear", d, 32'h0);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, '0, d); chk("R8 enable", d, 32'h1);

    // R9 interrupt gating
    wr(8'h04, 32'h0000_0040);
    pulse(32'h0000_0001);
    #1 chk("R9 unmasked bit no irq", {31'd0, irq_o}, 32'h0);
    pulse(32'h0000_0040);
    #1 chk("R9 masked bit irq", {31'd0, irq_o}, 32'h1);
    rd(8'h00, '0, d); chk("R9 status", d, 32'h0000_0041);
    #1 chk("R9 irq drops after read", {31'd0, irq_o}, 32'h0);
    wr(8'h08, 32'h0);
    pulse(32'h0000_0040);
    #1 chk("R9 disabled no irq", {31'd0, irq_o}, 32'h0);
    wr(8'h08, 32'h1);
    #1 chk("R9 enable raises irq", {31'd0, irq_o}, 32'h1);
    rd(8'h00, '0, d);

    // R5 summary drives irq through bit 15 mask
    wr(8'h04, 32'h0000_8000);
    pulse(32'h0080_0000);
    #1 chk("R5 summary irq", {31'd0, irq_o}, 32'h1);
    rd(8'h00, '0, d); chk("R5 summary read", d, 32'h0080_8000);
    #1 chk("R5 summary cleared", {31'd0, irq_o}, 32'h0);

    // R4 event in the clearing cycle
    pulse(32'h0000_0004);
    rd(8'h00, 32'h0000_0008, d); chk("R4 read excludes new", d, 32'h0000_0004);
    rd(8'h00, '0, d); chk("R4 new event kept", d, 32'h0000_0008);

    // R10 status write ignored, unused offsets
    pulse(32'h0000_0002);
    wr(8'h00, 32'h0000_0000);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, '0, d); chk("R10 status write ignored", d, 32'h0000_0002);
    rd(8'h0C, '0, d); chk("R10 unused offset", d, 32'h0);

    // R1 reset again clears registers
    pulse(32'h0000_0010);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    rd(8'h00, '0, d); chk("R1 status after reset", d, 32'h0);
    rd(8'h04, '0, d); chk("R1 mask after reset", d, 32'h0);

    finish_run();
  end
endmodule